// File: doc/BRIEF.md
# Calibration-Table Register Loader

The loader replays a calibration image held in a read-only memory into the register space of an attached device. On a start pulse it fetches the first 16-bit halfword of the image and treats it as a signature. A valid signature lets the loader write two setup values into the device's configuration space. It then walks a list of three-halfword records, each turning into one 32-bit register write. Each record write is followed by a fixed settling pause. A reserved marker halfword at the head of a record ends the list. If the signature is wrong, the loader stops at once and issues no write. A parameter caps the number of records, so a damaged image cannot run on without end.

Both data interfaces use valid/ready handshakes. On the read side, a request carrying a halfword address is held until the memory raises ready. The response is taken when the memory raises valid while the loader shows ready. The memory may stall either phase for any number of cycles. On the write side, the loader raises valid with a stable address, data and space flag, and keeps all of them unchanged until the target raises ready. One transfer completes in every cycle where valid and ready are both high. The loader never has more than one read or one write outstanding, so back-pressure on either side only stretches the sequence and never reorders it. Start, variant select, busy, done and the status flags are plain level or pulse signals.

Top module: `cal_loader`

## Requirements
- R1: After reset, busy, done, the not-calibrated flag, the overflow flag, the write count, the read request valid and the write valid are all low.
- R2: The halfword at image address 0 must be 0xA55A or 0x5AA5. For any other value the loader raises the not-calibrated flag, pulses done and issues no write at all.
- R3: With a good signature, the loader first issues a configuration write (wr_cfg_o = 1) to offset 0x10. The data is 0x0000FFFF when variant_i was low at start, or 0x1000FFFF when it was high. A configuration write of 0x00000006 to offset 0x04 follows.
- R4: Records start at halfword address REC_BASE and each takes three consecutive halfwords: an address offset, then data bits 15:0, then data bits 31:16. Each record produces one register write (wr_cfg_o = 0) to BASE_ADDR plus the offset, with the assembled 32-bit data.
- R5: The walk ends when the first halfword of a record reads 0xFFFF. The value 0xFFFF inside a data halfword does not end it.
- R6: After each record write handshake, the next read request rises exactly PAUSE_CYC cycles later, where PAUSE_CYC = CLK_FREQ_HZ / 1,000,000 × PAUSE_US.
- R7: Once MAX_RECORDS record writes have been issued, a following record head that is not 0xFFFF sets the overflow flag and ends the walk without a further write. A list of exactly MAX_RECORDS records followed by 0xFFFF completes without overflow.
- R8: A read request holds its address, and a write request holds its address, data and space flag, unchanged until the matching ready is seen.
- R9: Start is ignored while busy. Done is a single-cycle pulse, and busy is low in that cycle. The status flags hold until the next accepted start, which clears them.
- R10: wr_count_o counts record writes only, not configuration writes. It is cleared by an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, taken only when idle |
| variant_i | input | 1 | Selects the alternate BAR setup value, sampled at start |
| rd_req_valid_o | output | 1 | Halfword read request valid |
| rd_req_ready_i | input | 1 | Memory accepts the request |
| rd_req_addr_o | output | ADDR_W | Halfword address of the request |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_ready_o | output | 1 | Loader accepts read data |
| rd_rsp_data_i | input | 16 | Read halfword |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Target accepts the write |
| wr_cfg_o | output | 1 | 1 = configuration space, 0 = register space |
| wr_addr_o | output | 32 | Write address or configuration offset |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| not_cal_o | output | 1 | Signature was invalid on the last run |
| overflow_o | output | 1 | Record limit hit without end marker on the last run |
| wr_count_o | output | $clog2(MAX_RECORDS+1) | Record writes issued in the last run |

## Verification
If the record pointer drifts, the very next write carries a wrong address or data half. The scoreboard flags it on that handshake, one record after the fault. A wrong sequencer state shows up as a missing or extra configuration write, or as a write after a bad signature, before the first record is fetched. If the pause counter is off by even one cycle, the measured gap between a record handshake and the next read request is wrong right after the first record. A bad limit compare shows in the overflow flag and the write count when done pulses.

// File: rtl/cal_loader_pkg.sv
package cal_loader_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SIG, S_BAR, S_CMD, S_OFS, S_LO, S_HI, S_REC, S_PAUSE
  } ld_state_t;

  localparam logic [15:0] SIG_A    = 16'hA55A;
  localparam logic [15:0] SIG_B    = 16'h5AA5;
  localparam logic [15:0] END_MARK = 16'hFFFF;

  localparam logic [31:0] CFG_BAR_OFS = 32'h0000_0010;
  localparam logic [31:0] CFG_CMD_OFS = 32'h0000_0004;
  localparam logic [31:0] BAR_PLAIN   = 32'h0000_FFFF;
  localparam logic [31:0] BAR_ALT     = 32'h1000_FFFF;
  localparam logic [31:0] CMD_VAL     = 32'h0000_0006;

  typedef struct packed {
    logic        cfg;
    logic [31:0] addr;
    logic [31:0] data;
  } wr_req_t;

endpackage

// File: rtl/cal_hw_fetch.sv
module cal_hw_fetch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [15:0]       rd_rsp_data_i,
  output logic              hw_valid,
  output logic [15:0]       hw_data
);
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_RSP} f_state_t;
  f_state_t          fst;
  logic [ADDR_W-1:0] addr_q;

  assign rd_req_valid_o = (fst == F_REQ);
  assign rd_req_addr_o  = addr_q;
  assign rd_rsp_ready_o = (fst == F_RSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst      <= F_IDLE;
      addr_q   <= '0;
      hw_valid <= 1'b0;
      hw_data  <= '0;
    end else begin
      hw_valid <= 1'b0;
      case (fst)
        F_IDLE: if (go) begin
          addr_q <= go_addr;
          fst    <= F_REQ;
        end
        F_REQ: if (rd_req_ready_i) fst <= F_RSP;
        F_RSP: if (rd_rsp_valid_i) begin
          hw_valid <= 1'b1;
          hw_data  <= rd_rsp_data_i;
          fst      <= F_IDLE;
        end
        default: fst <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cal_pacer.sv
module cal_pacer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] START_VAL = CW'(CYCLES - 1);

  logic          running;
  logic [CW-1:0] cnt;

  assign expire = running && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (load) begin
      running <= 1'b1;
      cnt     <= START_VAL;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cal_wr_port.sv
module cal_wr_port
  import cal_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  wr_req_t     req,
  output logic        ack,
  output logic        wr_valid_o,
  input  logic        wr_ready_i,
  output logic        wr_cfg_o,
  output logic [31:0] wr_addr_o,
  output logic [31:0] wr_data_o
);
  wr_req_t hold_q;

  assign ack       = wr_valid_o && wr_ready_i;
  assign wr_cfg_o  = hold_q.cfg;
  assign wr_addr_o = hold_q.addr;
  assign wr_data_o = hold_q.data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid_o <= 1'b0;
      hold_q     <= '0;
    end else if (load) begin
      wr_valid_o <= 1'b1;
      hold_q     <= req;
    end else if (ack) begin
      wr_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_loader.sv
module cal_loader
  import cal_loader_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          REC_BASE    = 64,
  parameter int          MAX_RECORDS = 256,
  parameter int          CLK_FREQ_HZ = 200_000_000,
  parameter int          PAUSE_US    = 100,
  parameter logic [31:0] BASE_ADDR   = 32'h1000_0000,
  localparam int         CNT_W       = $clog2(MAX_RECORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              variant_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [15:0]       rd_rsp_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic              wr_cfg_o,
  output logic [31:0]       wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              not_cal_o,
  output logic              overflow_o,
  output logic [CNT_W-1:0]  wr_count_o
);
  localparam int PAUSE_RAW = (CLK_FREQ_HZ / 1_000_000) * PAUSE_US;
  localparam int PAUSE_CYC = (PAUSE_RAW < 1) ? 1 : PAUSE_RAW;
  localparam logic [ADDR_W-1:0] REC_BASE_A = ADDR_W'(REC_BASE);
  localparam logic [CNT_W-1:0]  MAX_C      = CNT_W'(MAX_RECORDS);

  ld_state_t         state;
  logic [ADDR_W-1:0] ptr;
  logic [15:0]       ofs_q, lo_q;
  logic              variant_q;

  logic              f_go, hw_valid;
  logic [ADDR_W-1:0] f_addr;
  logic [15:0]       hw_data;
  logic              w_load, w_ack, p_load, p_expire;
  wr_req_t           w_req;

  logic sig_ok, is_end, at_max;
  assign sig_ok = (hw_data == SIG_A) || (hw_data == SIG_B);
  assign is_end = (hw_data == END_MARK);
  assign at_max = (wr_count_o == MAX_C);
  assign busy_o = (state != S_IDLE);

  cal_hw_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(f_go), .go_addr(f_addr),
    .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
    .rd_req_addr_o(rd_req_addr_o), .rd_rsp_valid_i(rd_rsp_valid_i),
    .rd_rsp_ready_o(rd_rsp_ready_o), .rd_rsp_data_i(rd_rsp_data_i),
    .hw_valid(hw_valid), .hw_data(hw_data)
  );

  cal_pacer #(.CYCLES(PAUSE_CYC)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(p_load), .expire(p_expire)
  );

  cal_wr_port u_wr (
    .clk(clk), .rst_n(rst_n), .load(w_load), .req(w_req), .ack(w_ack),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_cfg_o(wr_cfg_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  // Launch logic for reads, writes and the pause timer
  always_comb begin
    f_go   = 1'b0;
    f_addr = ptr;
    w_load = 1'b0;
    w_req  = '0;
    p_load = 1'b0;
    case (state)
      S_IDLE: if (start_i) begin
        f_go   = 1'b1;
        f_addr = '0;
      end
      S_SIG: if (hw_valid && sig_ok) begin
        w_load     = 1'b1;
        w_req.cfg  = 1'b1;
        w_req.addr = CFG_BAR_OFS;
        w_req.data = variant_q ? BAR_ALT : BAR_PLAIN;
      end
      S_BAR: if (w_ack) begin
        w_load     = 1'b1;
        w_req.cfg  = 1'b1;
        w_req.addr = CFG_CMD_OFS;
        w_req.data = CMD_VAL;
      end
      S_CMD: if (w_ack) begin
        f_go   = 1'b1;
        f_addr = REC_BASE_A;
      end
      S_OFS: if (hw_valid && !is_end && !at_max) begin
        f_go   = 1'b1;
        f_addr = ptr + ADDR_W'(1);
      end
      S_LO: if (hw_valid) begin
        f_go   = 1'b1;
        f_addr = ptr + ADDR_W'(2);
      end
      S_HI: if (hw_valid) begin
        w_load     = 1'b1;
        w_req.cfg  = 1'b0;
        w_req.addr = BASE_ADDR + {16'h0000, ofs_q};
        w_req.data = {hw_data, lo_q};
      end
      S_REC:   if (w_ack) p_load = 1'b1;
      S_PAUSE: if (p_expire) begin
        f_go   = 1'b1;
        f_addr = ptr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ptr        <= '0;
      ofs_q      <= '0;
      lo_q       <= '0;
      variant_q  <= 1'b0;
      done_o     <= 1'b0;
      not_cal_o  <= 1'b0;
      overflow_o <= 1'b0;
      wr_count_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          variant_q  <= variant_i;
          not_cal_o  <= 1'b0;
          overflow_o <= 1'b0;
          wr_count_o <= '0;
          state      <= S_SIG;
        end
        S_SIG: if (hw_valid) begin
          if (sig_ok) state <= S_BAR;
          else begin
            not_cal_o <= 1'b1;
            done_o    <= 1'b1;
            state     <= S_IDLE;
          end
        end
        S_BAR: if (w_ack) state <= S_CMD;
        S_CMD: if (w_ack) begin
          ptr   <= REC_BASE_A;
          state <= S_OFS;
        end
        S_OFS: if (hw_valid) begin
          if (is_end) begin
            done_o <= 1'b1;
            state  <= S_IDLE;
          end else if (at_max) begin
            overflow_o <= 1'b1;
            done_o     <= 1'b1;
            state      <= S_IDLE;
          end else begin
            ofs_q <= hw_data;
            state <= S_LO;
          end
        end
        S_LO: if (hw_valid) begin
          lo_q  <= hw_data;
          state <= S_HI;
        end
        S_HI: if (hw_valid) state <= S_REC;
        S_REC: if (w_ack) begin
          wr_count_o <= wr_count_o + 1'b1;
          ptr        <= ptr + ADDR_W'(3);
          state      <= S_PAUSE;
        end
        S_PAUSE: if (p_expire) state <= S_OFS;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cal_loader_chk.sv
module cal_loader_chk #(
  parameter int          ADDR_W      = 16,
  parameter int          MAX_RECORDS = 256,
  parameter int          CLK_FREQ_HZ = 200_000_000,
  parameter int          PAUSE_US    = 100,
  parameter logic [31:0] BASE_ADDR   = 32'h1000_0000,
  localparam int         CNT_W       = $clog2(MAX_RECORDS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              not_cal_o,
  input logic              overflow_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic              wr_cfg_o,
  input logic [31:0]       wr_addr_o,
  input logic [31:0]       wr_data_o,
  input logic              rd_req_valid_o,
  input logic              rd_req_ready_i,
  input logic [ADDR_W-1:0] rd_req_addr_o,
  input logic [CNT_W-1:0]  wr_count_o
);
  localparam int PAUSE_RAW = (CLK_FREQ_HZ / 1_000_000) * PAUSE_US;
  localparam int PAUSE_CYC = (PAUSE_RAW < 1) ? 1 : PAUSE_RAW;

  int unsigned gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 0;
    else if (wr_valid_o && wr_ready_i && !wr_cfg_o) gap <= PAUSE_CYC;
    else if (gap != 0) gap <= gap - 1;
  end

  a_r6_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (gap != 0) |-> !rd_req_valid_o);

  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)
      && $stable(wr_data_o) && $stable(wr_cfg_o)));

  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r2_notcal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    not_cal_o |-> (!wr_valid_o && !busy_o && wr_count_o == '0));

  a_r7_overflow_idle: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> !busy_o);

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count_o <= CNT_W'(MAX_RECORDS));

  a_r3_cfg_target: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_cfg_o) |-> (wr_addr_o == 32'h10 || wr_addr_o == 32'h04));

  a_r4_rec_window: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_cfg_o) |-> ((wr_addr_o - BASE_ADDR) <= 32'h0000_FFFF));

  a_r10_cfg_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && wr_cfg_o) |=> $stable(wr_count_o));
endmodule

bind cal_loader cal_loader_chk #(
  .ADDR_W(ADDR_W), .MAX_RECORDS(MAX_RECORDS), .CLK_FREQ_HZ(CLK_FREQ_HZ),
  .PAUSE_US(PAUSE_US), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .not_cal_o(not_cal_o), .overflow_o(overflow_o), .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i), .wr_cfg_o(wr_cfg_o), .wr_addr_o(wr_addr_o),
  .wr_data_o(wr_data_o), .rd_req_valid_o(rd_req_valid_o),
  .rd_req_ready_i(rd_req_ready_i), .rd_req_addr_o(rd_req_addr_o),
  .wr_count_o(wr_count_o)
);

// File: tb/cal_loader_bench.sv
`timescale 1ns/1ps
module cal_loader_bench;
  localparam int ADDR_W    = 8;
  localparam int REC_BASE  = 8;
  localparam int MAX_REC   = 4;
  localparam int CLK_HZ    = 1_000_000;
  localparam int PAUSE_US  = 20;
  localparam int PAUSE_CYC = (CLK_HZ / 1_000_000) * PAUSE_US;
  localparam int CW        = $clog2(MAX_REC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic variant_i = 1'b0;
  logic rd_req_valid_o, rd_req_ready_i, rd_rsp_valid_i, rd_rsp_ready_o;
  logic [ADDR_W-1:0] rd_req_addr_o;
  logic [15:0] rd_rsp_data_i;
  logic wr_valid_o, wr_ready_i, wr_cfg_o;
  logic [31:0] wr_addr_o, wr_data_o;
  logic busy_o, done_o, not_cal_o, overflow_o;
  logic [CW-1:0] wr_count_o;

  always #2.5 clk = ~clk;

  cal_loader #(
    .ADDR_W(ADDR_W), .REC_BASE(REC_BASE), .MAX_RECORDS(MAX_REC),
    .CLK_FREQ_HZ(CLK_HZ), .PAUSE_US(PAUSE_US), .BASE_ADDR(32'h1000_0000)
  ) u_cal_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .variant_i(variant_i),
    .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
    .rd_req_addr_o(rd_req_addr_o), .rd_rsp_valid_i(rd_rsp_valid_i),
    .rd_rsp_ready_o(rd_rsp_ready_o), .rd_rsp_data_i(rd_rsp_data_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_cfg_o(wr_cfg_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
    .done_o(done_o), .not_cal_o(not_cal_o), .overflow_o(overflow_o),
    .wr_count_o(wr_count_o)
  );

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  int done_seen = 0;
  logic [15:0] mem [64];
  logic [64:0] expq [$];
  logic [15:0] r_ofs [6];
  logic [15:0] r_lo [6];
  logic [15:0] r_hi [6];

  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Memory responder: variable acceptance and response latency
  initial begin : mem_model
    int lat;
    bit pend, taken;
    logic [ADDR_W-1:0] a;
    lat = 0; pend = 0; taken = 0; a = '0;
    rd_req_ready_i = 0; rd_rsp_valid_i = 0; rd_rsp_data_i = '0;
    forever begin
      @(negedge clk);
      if (taken) begin rd_rsp_valid_i = 0; taken = 0; end
      if (pend) begin
        if (lat == 0) begin
          rd_rsp_valid_i = 1;
          rd_rsp_data_i  = mem[a[5:0]];
          pend = 0;
        end else lat--;
      end
      if (rd_rsp_valid_i && rd_rsp_ready_o) taken = 1;
      rd_req_ready_i = (ncyc % 3 != 0) && !pend && !rd_rsp_valid_i;
      if (rd_req_ready_i && rd_req_valid_o) begin
        a = rd_req_addr_o;
        lat = ncyc % 3;
        pend = 1;
      end
    end
  end

  // Write target and scoreboard monitor
  initial begin : wr_monitor
    logic [64:0] got, e;
    bit gap_armed, done_prev;
    int hs_cyc;
    gap_armed = 0; done_prev = 0; hs_cyc = 0;
    wr_ready_i = 0;
    forever begin
      @(negedge clk);
      wr_ready_i = (ncyc % 4 != 1);
      if (wr_ready_i && wr_valid_o) begin
        got = {wr_cfg_o, wr_addr_o, wr_data_o};
        if (expq.size() == 0) check(1'b0, "R4 unexpected write", got, '0);
        else begin
          e = expq.pop_front();
          check(got == e, e[64] ? "R3 config write" : "R4 record write", got, e);
        end
        if (!wr_cfg_o) begin hs_cyc = ncyc + 1; gap_armed = 1; end
      end
      if (gap_armed && rd_req_valid_o) begin
        check(ncyc - hs_cyc == PAUSE_CYC, "R6 pause length", 65'(ncyc - hs_cyc), 65'(PAUSE_CYC));
        gap_armed = 0;
      end
      if (done_o) begin
        done_seen++;
        check(!busy_o, "R9 busy low with done", 65'(busy_o), 65'(0));
        if (done_prev) check(1'b0, "R9 done wider than one cycle", 65'(1), 65'(0));
      end
      done_prev = done_o;
    end
  end

  task automatic run_case(input logic [15:0] sig, input bit var_sel, input int n,
                          input bit sentinel, input bit poke_start);
    bit ok_sig;
    int nexp, d0;
    ok_sig = (sig == 16'hA55A) || (sig == 16'h5AA5);
    for (int i = 0; i < 64; i++) mem[i] = 16'h1111;
    mem[0] = sig;
    for (int i = 0; i < n; i++) begin
      mem[REC_BASE + 3*i]     = r_ofs[i];
      mem[REC_BASE + 3*i + 1] = r_lo[i];
      mem[REC_BASE + 3*i + 2] = r_hi[i];
    end
    if (sentinel) mem[REC_BASE + 3*n] = 16'hFFFF;
    nexp = ok_sig ? ((n > MAX_REC) ? MAX_REC : n) : 0;
    if (ok_sig) begin
      expq.push_back({1'b1, 32'h10, var_sel ? 32'h1000_FFFF : 32'h0000_FFFF});
      expq.push_back({1'b1, 32'h04, 32'h6});
      for (int i = 0; i < nexp; i++)
        expq.push_back({1'b0, 32'h1000_0000 + {16'h0, r_ofs[i]}, r_hi[i], r_lo[i]});
    end
    d0 = done_seen;
    @(negedge clk); variant_i = var_sel; start_i = 1;
    @(negedge clk); start_i = 0;
    if (poke_start) begin
      repeat (5) @(negedge clk);
      check(busy_o == 1'b1, "R9 busy during run", 65'(busy_o), 65'(1));
      variant_i = ~var_sel; start_i = 1;
      @(negedge clk); start_i = 0;
    end
    for (int t = 0; t < 3000 && done_seen == d0; t++) @(negedge clk);
    if (done_seen == d0) check(1'b0, "R9 run never finished", 65'(0), 65'(1));
    repeat (4) @(negedge clk);
    check(done_seen == d0 + 1, "R9 one done per run", 65'(done_seen - d0), 65'(1));
    check(expq.size() == 0, ok_sig ? "R4 all writes issued" : "R2 no writes on bad signature",
          65'(expq.size()), 65'(0));
    check(not_cal_o == !ok_sig, "R2 not-calibrated flag", 65'(not_cal_o), 65'(!ok_sig));
    check(overflow_o == (ok_sig && n > MAX_REC && !sentinel), "R7 overflow flag",
          65'(overflow_o), 65'(ok_sig && n > MAX_REC && !sentinel));
    check(wr_count_o == CW'(nexp), "R10 record write count", 65'(wr_count_o), 65'(nexp));
    check(!busy_o, "R9 idle after done", 65'(busy_o), 65'(0));
    expq.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    r_ofs[0] = 16'h0040; r_lo[0] = 16'hBEEF; r_hi[0] = 16'hDEAD;
    r_ofs[1] = 16'h1234; r_lo[1] = 16'hFFFF; r_hi[1] = 16'h0000;
    r_ofs[2] = 16'hFFFE; r_lo[2] = 16'h0001; r_hi[2] = 16'hFFFF;
    r_ofs[3] = 16'h0000; r_lo[3] = 16'h5555; r_hi[3] = 16'hAAAA;
    r_ofs[4] = 16'h8000; r_lo[4] = 16'h0F0F; r_hi[4] = 16'hF0F0;
    r_ofs[5] = 16'h0100; r_lo[5] = 16'h2222; r_hi[5] = 16'h3333;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o, "R1 busy/done after reset", {busy_o, done_o}, 65'(0));
    check(!not_cal_o && !overflow_o, "R1 flags after reset", {not_cal_o, overflow_o}, 65'(0));
    check(wr_count_o == '0, "R1 count after reset", 65'(wr_count_o), 65'(0));
    check(!rd_req_valid_o && !wr_valid_o, "R1 no requests after reset",
          {rd_req_valid_o, wr_valid_o}, 65'(0));
    // R2 bad signature
    run_case(16'h1234, 1'b0, 2, 1'b1, 1'b0);
    // R3 R4 R5 R6 R9: three records, 0xFFFF inside data, start poked while busy
    run_case(16'hA55A, 1'b0, 3, 1'b1, 1'b1);
    // R3 variant BAR, R5 marker as first record
    run_case(16'h5AA5, 1'b1, 0, 1'b1, 1'b0);
    // R7 exactly the limit then marker
    run_case(16'hA55A, 1'b1, 4, 1'b1, 1'b0);
    // R7 limit exceeded without marker
    run_case(16'h5AA5, 1'b0, 5, 1'b0, 1'b0);
    // R2 near-miss signature, also clears R7 flag (R9)
    run_case(16'h5A5A, 1'b0, 1, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule